// File: doc/BRIEF.md
# Cascadable Phase Accumulator with Load-Alignment Flags

This block is the phase engine of a numerically controlled oscillator. Every clock it adds a held frequency increment and a carry input to a wide accumulator. It then adds a held phase offset to the upper bits of that total and registers the top bits of the result as the phase word for a downstream sine/cosine converter. The carry out of the accumulator is registered as a one-clock pulse. Feeding that pulse into the carry input of a second copy builds a longer accumulator with finer frequency resolution.

The frequency and offset words each enter through their own load strobe. Each word then runs down a fixed-length register line, so a change reaches the phase output a set number of cycles after the load. Two active-low flags mark the cycle in which each kind of change has worked its way through. A second clock, the tap strobe, samples 12 upper bits of the modulated phase into a separate register that holds between strobes.

Cycle numbering used below: cycle 0 is the clock period whose closing rising edge of `clk` samples the relevant load strobe high. Cycle n is the period that follows n further rising edges.

Top module: `nco_phase_acc`

## Requirements
- R1: A rising edge with `rst` high clears the accumulator, the held frequency and offset words and both flag lines. In the following cycle `phaseOut` is 0, `carryOut` is 0, and `fSyncN` and `pSyncN` are 1. Loads and `carryIn` have no effect while `rst` is high.
- R2: At each rising edge without reset, the accumulator becomes (accumulator + increment + carryIn) mod 2^ACC_W. In the next cycle `phaseOut` equals bits [ACC_W-1:ACC_W-OUT_W] of (accumulator + offset·2^(ACC_W-OFF_W)) mod 2^ACC_W, so the offset occupies bits [ACC_W-1:ACC_W-OFF_W].
- R3: A frequency word loaded in cycle 0 is the increment used from cycle 16 on, with the default delay. The first `phaseOut` step that shows it is the one from cycle 17 to cycle 18.
- R4: A high `carryIn` adds one to the increment. An all-ones increment with `carryIn` high leaves the accumulator unchanged and raises `carryOut` every cycle.
- R5: `carryOut` is 1 for exactly one cycle for each addition whose unreduced total exceeds 2^ACC_W-1. That cycle follows the edge that stores the wrapped value.
- R6: An offset loaded in cycle 0 first appears on `phaseOut` in cycle 12. Up to cycle 11 the output still uses the previous offset.
- R7: `pSyncN` idles at 1 and is 0 only in cycle 11 after an offset load. A frequency load does not move it.
- R8: `fSyncN` idles at 1 and is 0 only in cycle 18 after a frequency load. An offset load does not move it.
- R9: A load of the same kind arriving while an earlier flag is still pending restarts that flag's delay. Only one low pulse follows, timed from the latest load.
- R10: On each rising edge of `tapClk`, `phaseTap` takes bits [ACC_W-1:ACC_W-TAP_W] of the accumulator-plus-offset sum present at that moment. It holds that value until the next tap edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Main clock |
| rst | input | 1 | Synchronous reset, active high |
| freqLoad | input | 1 | Strobe that captures `freqWord` |
| freqWord | input | ACC_W | Frequency increment |
| phaseLoad | input | 1 | Strobe that captures `phaseWord` |
| phaseWord | input | OFF_W | Phase offset, aligned to the accumulator MSBs |
| carryIn | input | 1 | Carry into the accumulator LSB (cascade input) |
| tapClk | input | 1 | Strobe clock for the phase tap register |
| phaseOut | output | OUT_W | Modulated phase for the amplitude stage |
| carryOut | output | 1 | One-cycle accumulator wrap pulse (cascade output) |
| phaseTap | output | TAP_W | Phase sample frozen on `tapClk` |
| fSyncN | output | 1 | Active-low flag: frequency change has arrived |
| pSyncN | output | 1 | Active-low flag: offset change has arrived |

## Verification
The bench builds the block with a 16-bit accumulator and keeps every other parameter at its default. This leaves 13 output bits above 3 fractional bits. A wrap then needs only four cycles at an increment of 0x4000, and the all-ones increment case is short. Small increments that are multiples of 8 show up exactly on `phaseOut`, so the 16-cycle frequency line, the 12-cycle offset path and the carry into the LSB can all be read straight off the output. The flag delays of 11 and 18 keep their default values, so the exact flag cycles and the restart behaviour are observed at their real lengths.

// File: rtl/nco_phase_acc_pkg.sv
package nco_phase_acc_pkg;

  // Strobes issued by the control section to the datapath.
  typedef struct packed {
    logic clearAll;
    logic takeFreq;
    logic takePhase;
  } ncoStrobe_t;

endpackage

// File: rtl/nco_flag_line.sv
// Delay line for one active-low arrival flag; a new start restarts it.
module nco_flag_line #(
  parameter int DEPTH = 11
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic flagN
);
  localparam int LAST = DEPTH - 1;

  logic [LAST:0] line;

  always_ff @(posedge clk) begin
    if (rst) begin
      line <= '0;
    end else if (start) begin
      line <= {{LAST{1'b0}}, 1'b1};
    end else begin
      line <= {line[LAST-1:0], 1'b0};
    end
  end

  assign flagN = ~line[LAST];

  // R7 / R8: the flag is low for a single cycle at a time
  a_r7_r8_one_clock_pulse: assert property (@(posedge clk) disable iff (rst)
    !flagN |=> flagN);

  // R9: a start clears any pending pulse, so the flag is high the next cycle
  a_r9_restart_clears: assert property (@(posedge clk) disable iff (rst)
    start |=> flagN);

endmodule

// File: rtl/nco_phase_acc_ctl.sv
// Control section: qualifies the load strobes and runs the two flag lines.
module nco_phase_acc_ctl
  import nco_phase_acc_pkg::*;
#(
  parameter int FSYNC_DLY = 18,
  parameter int PSYNC_DLY = 11
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       freqLoad,
  input  logic       phaseLoad,
  output ncoStrobe_t strobes,
  output logic       fSyncN,
  output logic       pSyncN
);

  always_comb begin
    strobes.clearAll  = rst;
    strobes.takeFreq  = freqLoad & ~rst;
    strobes.takePhase = phaseLoad & ~rst;
  end

  nco_flag_line #(.DEPTH(FSYNC_DLY)) uFreqFlag (
    .clk   (clk),
    .rst   (rst),
    .start (strobes.takeFreq),
    .flagN (fSyncN)
  );

  nco_flag_line #(.DEPTH(PSYNC_DLY)) uPhaseFlag (
    .clk   (clk),
    .rst   (rst),
    .start (strobes.takePhase),
    .flagN (pSyncN)
  );

endmodule

// File: rtl/nco_phase_acc_dp.sv
// Datapath: word delay lines, accumulator, offset adder, phase tap.
module nco_phase_acc_dp
  import nco_phase_acc_pkg::*;
#(
  parameter int ACC_W       = 32,
  parameter int OFF_W       = 12,
  parameter int OUT_W       = 13,
  parameter int TAP_W       = 12,
  parameter int FREQ_STAGES = 16,
  parameter int OFF_STAGES  = 11
) (
  input  logic              clk,
  input  logic              tapClk,
  input  ncoStrobe_t        strobes,
  input  logic [ACC_W-1:0]  freqWord,
  input  logic [OFF_W-1:0]  phaseWord,
  input  logic              carryIn,
  output logic [OUT_W-1:0]  phaseOut,
  output logic              carryOut,
  output logic [TAP_W-1:0]  phaseTap
);
  localparam int PAD_W = OUT_W - OFF_W;

  logic [ACC_W-1:0] freqPipe [FREQ_STAGES];
  logic [OFF_W-1:0] offPipe  [OFF_STAGES];
  logic [ACC_W-1:0] acc;
  logic [ACC_W-1:0] accNext;
  logic             carryNext;
  logic [OUT_W-1:0] offAligned;
  logic [OUT_W-1:0] phaseTop;

  // Word delay lines: stage 0 holds the captured word, later stages follow.
  always_ff @(posedge clk) begin
    if (strobes.clearAll) begin
      for (int k = 0; k < FREQ_STAGES; k++) freqPipe[k] <= '0;
      for (int k = 0; k < OFF_STAGES; k++)  offPipe[k]  <= '0;
    end else begin
      if (strobes.takeFreq)  freqPipe[0] <= freqWord;
      if (strobes.takePhase) offPipe[0]  <= phaseWord;
      for (int k = 1; k < FREQ_STAGES; k++) freqPipe[k] <= freqPipe[k-1];
      for (int k = 1; k < OFF_STAGES; k++)  offPipe[k]  <= offPipe[k-1];
    end
  end

  // Accumulator with cascade carry.
  assign {carryNext, accNext} = {1'b0, acc} + {1'b0, freqPipe[FREQ_STAGES-1]}
                              + {{ACC_W{1'b0}}, carryIn};

  always_ff @(posedge clk) begin
    if (strobes.clearAll) begin
      acc      <= '0;
      carryOut <= 1'b0;
    end else begin
      acc      <= accNext;
      carryOut <= carryNext;
    end
  end

  // Offset sits on the accumulator MSBs, so only the upper bits need adding.
  generate
    if (PAD_W > 0) begin : gPad
      assign offAligned = {offPipe[OFF_STAGES-1], {PAD_W{1'b0}}};
    end else begin : gNoPad
      assign offAligned = offPipe[OFF_STAGES-1];
    end
  endgenerate

  assign phaseTop = acc[ACC_W-1 -: OUT_W] + offAligned;

  always_ff @(posedge clk) begin
    if (strobes.clearAll) phaseOut <= '0;
    else                  phaseOut <= phaseTop;
  end

  always_ff @(posedge tapClk) begin
    phaseTap <= phaseTop[OUT_W-1 -: TAP_W];
  end

  // R1: reset leaves output and carry at zero
  a_r1_reset_clear: assert property (@(posedge clk)
    strobes.clearAll |=> (phaseOut == '0 && !carryOut));

  // R5: a carry pulse only follows a wrap of the accumulator
  a_r5_carry_means_wrap: assert property (@(posedge clk) disable iff (strobes.clearAll)
    (carryOut && !$past(strobes.clearAll)) |-> (acc <= $past(acc)));

  // R2: without a carry the accumulator never moves backwards
  a_r2_no_carry_no_wrap: assert property (@(posedge clk) disable iff (strobes.clearAll)
    (!carryOut && !$past(strobes.clearAll)) |-> (acc >= $past(acc)));

endmodule

// File: rtl/nco_phase_acc.sv
// Thin top: control section plus datapath.
module nco_phase_acc
  import nco_phase_acc_pkg::*;
#(
  parameter int ACC_W     = 32,
  parameter int OFF_W     = 12,
  parameter int OUT_W     = 13,
  parameter int TAP_W     = 12,
  parameter int PHASE_LAT = 12,
  parameter int PSYNC_DLY = 11,
  parameter int FSYNC_DLY = 18
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             freqLoad,
  input  logic [ACC_W-1:0] freqWord,
  input  logic             phaseLoad,
  input  logic [OFF_W-1:0] phaseWord,
  input  logic             carryIn,
  input  logic             tapClk,
  output logic [OUT_W-1:0] phaseOut,
  output logic             carryOut,
  output logic [TAP_W-1:0] phaseTap,
  output logic             fSyncN,
  output logic             pSyncN
);
  // Frequency: one capture stage plus the line, then accumulator and output registers.
  localparam int FREQ_STAGES = FSYNC_DLY - 2;
  // Offset: line stages, then the output register.
  localparam int OFF_STAGES  = PHASE_LAT - 1;

  ncoStrobe_t strobes;

  nco_phase_acc_ctl #(
    .FSYNC_DLY (FSYNC_DLY),
    .PSYNC_DLY (PSYNC_DLY)
  ) uCtl (
    .clk       (clk),
    .rst       (rst),
    .freqLoad  (freqLoad),
    .phaseLoad (phaseLoad),
    .strobes   (strobes),
    .fSyncN    (fSyncN),
    .pSyncN    (pSyncN)
  );

  nco_phase_acc_dp #(
    .ACC_W       (ACC_W),
    .OFF_W       (OFF_W),
    .OUT_W       (OUT_W),
    .TAP_W       (TAP_W),
    .FREQ_STAGES (FREQ_STAGES),
    .OFF_STAGES  (OFF_STAGES)
  ) uDp (
    .clk       (clk),
    .tapClk    (tapClk),
    .strobes   (strobes),
    .freqWord  (freqWord),
    .phaseWord (phaseWord),
    .carryIn   (carryIn),
    .phaseOut  (phaseOut),
    .carryOut  (carryOut),
    .phaseTap  (phaseTap)
  );

endmodule

// File: tb/sim_nco_phase_acc.sv
`timescale 1ns/1ps
module sim_nco_phase_acc;
  localparam int ACC_W = 16;
  localparam int OFF_W = 12;
  localparam int OUT_W = 13;
  localparam int TAP_W = 12;
  localparam int LOGN  = 64;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             freqLoad = 1'b0;
  logic [ACC_W-1:0] freqWord = '0;
  logic             phaseLoad = 1'b0;
  logic [OFF_W-1:0] phaseWord = '0;
  logic             carryIn = 1'b0;
  logic             tapClk = 1'b0;
  logic [OUT_W-1:0] phaseOut;
  logic             carryOut;
  logic [TAP_W-1:0] phaseTap;
  logic             fSyncN;
  logic             pSyncN;

  int checks = 0;
  int errors = 0;

  logic [OUT_W-1:0] phaseLog [LOGN];
  logic [TAP_W-1:0] tapLog   [LOGN];
  logic             cLog     [LOGN];
  logic             fLog     [LOGN];
  logic             pLog     [LOGN];

  always #4 clk = ~clk;

  nco_phase_acc #(.ACC_W(ACC_W)) u0 (
    .clk       (clk),
    .rst       (rst),
    .freqLoad  (freqLoad),
    .freqWord  (freqWord),
    .phaseLoad (phaseLoad),
    .phaseWord (phaseWord),
    .carryIn   (carryIn),
    .tapClk    (tapClk),
    .phaseOut  (phaseOut),
    .carryOut  (carryOut),
    .phaseTap  (phaseTap),
    .fSyncN    (fSyncN),
    .pSyncN    (pSyncN)
  );

  // Vector: {increment, carryIn, sample cycle, expected phaseOut}
  localparam logic [47:0] VEC [7] = '{
    {16'h0008, 8'd0, 8'd20, 16'd3},
    {16'h0100, 8'd1, 8'd30, 16'd419},
    {16'hFFF8, 8'd0, 8'd19, 16'd8190},
    {16'h0000, 8'd1, 8'd10, 16'd1},
    {16'h1000, 8'd0, 8'd40, 16'd3584},
    {16'h0808, 8'd1, 8'd17, 16'd2},
    {16'h0808, 8'd1, 8'd18, 16'd259}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Reset, then drive cycles 0..LOGN-1, logging outputs in each cycle.
  task automatic run(input logic [ACC_W-1:0] f, input logic cin, input int fa, input int fb,
                     input logic [OFF_W-1:0] o, input int pa, input int pb, input int ta);
    @(negedge clk);
    rst = 1'b1; freqLoad = 1'b0; phaseLoad = 1'b0; carryIn = 1'b0;
    repeat (2) @(posedge clk);
    for (int c = 0; c < LOGN; c++) begin
      @(negedge clk);
      rst       = 1'b0;
      carryIn   = cin;
      freqWord  = f;
      phaseWord = o;
      freqLoad  = (c == fa) || (c == fb);
      phaseLoad = (c == pa) || (c == pb);
      phaseLog[c] = phaseOut;
      tapLog[c]   = phaseTap;
      cLog[c]     = carryOut;
      fLog[c]     = fSyncN;
      pLog[c]     = pSyncN;
      if (c == ta) begin
        #1 tapClk = 1'b1;
        #1 tapClk = 1'b0;
      end
    end
    @(negedge clk);
    freqLoad = 1'b0; phaseLoad = 1'b0;
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int ones;
    // Table walk: R2 accumulation, R3 frequency latency, R4 carry input
    for (int v = 0; v < 7; v++) begin
      run(VEC[v][47:32], VEC[v][24], 0, -1, '0, -1, -1, -1);
      check("R2/R3/R4 phaseOut", phaseLog[VEC[v][23:16]], VEC[v][15:0]);
      check("R8 fSyncN before", fLog[17], 1);
      check("R8 fSyncN low", fLog[18], 0);
      check("R8 fSyncN after", fLog[19], 1);
      check("R7 pSyncN unmoved", pLog[11], 1);
      if (v == 0) begin
        check("R1 phaseOut reset", phaseLog[0], 0);
        check("R1 carryOut reset", cLog[0], 0);
        check("R1 fSyncN reset", fLog[0], 1);
        check("R1 pSyncN reset", pLog[0], 1);
      end
    end

    // R5: wrap every four cycles from cycle 20
    run(16'h4000, 1'b0, 0, -1, '0, -1, -1, -1);
    check("R5 no carry before wrap", cLog[19], 0);
    check("R5 carry at wrap", cLog[20], 1);
    check("R5 carry one cycle", cLog[21], 0);
    check("R5 wrapped phase", phaseLog[21], 0);
    ones = 0;
    for (int c = 0; c <= 40; c++) if (cLog[c]) ones++;
    check("R5 wrap count", ones, 6);

    // R4: all-ones increment plus carryIn holds the accumulator
    run(16'hFFFF, 1'b1, 0, -1, '0, -1, -1, -1);
    check("R4 no carry before", cLog[16], 0);
    check("R4 carry each cycle a", cLog[17], 1);
    check("R4 carry each cycle b", cLog[30], 1);
    check("R4 phase held", phaseLog[40], 2);

    // R6 / R7: offset latency and phase flag
    run('0, 1'b0, -1, -1, 12'h123, 0, -1, -1);
    check("R6 old offset cycle 11", phaseLog[11], 0);
    check("R6 new offset cycle 12", phaseLog[12], 582);
    check("R7 pSyncN before", pLog[10], 1);
    check("R7 pSyncN low", pLog[11], 0);
    check("R7 pSyncN after", pLog[12], 1);
    check("R8 fSyncN unmoved", fLog[18], 1);

    // R9: repeated loads restart each flag line
    run(16'h0010, 1'b0, 0, 3, 12'h040, 0, 5, -1);
    check("R9 pSyncN first suppressed", pLog[11], 1);
    check("R9 pSyncN from latest", pLog[16], 0);
    check("R9 fSyncN first suppressed", fLog[18], 1);
    check("R9 fSyncN from latest", fLog[21], 0);
    ones = 0;
    for (int c = 0; c < LOGN; c++) if (!pLog[c]) ones++;
    check("R9 single phase pulse", ones, 1);

    // R10: phase tap sampled on tapClk in cycle 30 and held
    run(16'h0010, 1'b0, 0, -1, '0, -1, -1, 30);
    check("R10 tap sampled", tapLog[31], 14);
    check("R10 tap held", tapLog[40], 14);
    check("R10 phase moved on", phaseLog[40], 46);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule